// File: doc/BRIEF.md
# Calibrated Current and Power Calculator

This block turns each pair of raw conversion readings into scaled current and power results. Every conversion strobe carries a signed shunt-voltage count and an unsigned bus-voltage count. The shunt count is multiplied by a software-written calibration word and scaled down by the fixed internal resolution of 4096 (a 12-bit right shift). The result is a signed current value that saturates at the limits of its range.

The magnitude of that current is then multiplied by the bus count, doubled when the high bus range is selected, and divided by 5000 in a bit-serial divider. The quotient is clamped to the unsigned maximum to give the power value. Both result registers update on the same clock edge, and a one-cycle done pulse marks that edge. While the calibration word is zero, both results read zero.

Top module: `cal_power_calc`

## Requirements
- R1: After reset, `current_out`, `power_out` and `cal_out` are all zero and `done` is low.
- R2: When `cal_we` is high at a clock edge, `cal_wdata` is stored and appears on `cal_out` after that edge.
- R3: The current result is floor(shunt × cal / 4096). The shunt count is two's complement, the calibration word is unsigned, and the result is in two's complement with bit 15 weighted −32768.
- R4: A current above 32767 saturates to 32767 (0x7FFF), and a current below −32768 saturates to −32768 (0x8000).
- R5: With `bus_range_hi` low, the power result is floor(|current| × bus / 5000). Here current is the saturated current result of the same conversion.
- R6: With `bus_range_hi` high, the power result is floor(2 × |current| × bus / 5000).
- R7: A power quotient above 65535 saturates to 0xFFFF.
- R8: Once the calibration register holds zero, both results read zero from the second edge after the write onward. Conversions made while it is zero leave them at zero.
- R9: An accepted strobe is followed, 35 clock edges later, by a single-cycle `done` pulse. On that edge both results change together, and between pulses they hold their values.
- R10: A `conv_valid` strobe that arrives while a conversion is in progress is ignored. It starts no conversion, and the pending results belong to the earlier strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_we | input | 1 | Calibration register write enable |
| cal_wdata | input | 16 | Calibration word to write |
| conv_valid | input | 1 | Strobe: new readings present on the inputs |
| shunt_in | input | 16 | Signed shunt-voltage count |
| bus_in | input | 16 | Unsigned bus-voltage count |
| bus_range_hi | input | 1 | High bus range select; doubles the power result |
| current_out | output | 16 | Signed current result |
| power_out | output | 16 | Unsigned power result |
| cal_out | output | 16 | Calibration register read-back |
| done | output | 1 | One-cycle pulse when the results update |

## Verification
The bench builds the block with its default widths: 16-bit shunt, bus, calibration and result words, a 12-bit fraction and a divisor of 5000. These widths make a 34-bit numerator and a 35-edge latency. Full-scale 16-bit stimulus then reaches both current clamps and the power clamp. A calibration of 4096 gives an identity current path, so the power arithmetic can be checked on its own. Small odd calibrations show the floor rounding of negative products.

// File: rtl/pcalc_pkg.sv
package pcalc_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_st_t;
endpackage

// File: rtl/pcalc_cur_scale.sv
module pcalc_cur_scale #(
  parameter int SHUNT_W   = 16,
  parameter int CAL_W     = 16,
  parameter int FRAC_BITS = 12,
  parameter int OUT_W     = 16
) (
  input  logic signed [SHUNT_W-1:0] shunt,
  input  logic        [CAL_W-1:0]   cal,
  output logic signed [OUT_W-1:0]   cur,
  output logic        [OUT_W:0]     mag
);
  localparam int PW = SHUNT_W + CAL_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  shifted;
  logic signed [OUT_W:0] cext;

  always_comb begin
    prod    = PW'(shunt) * PW'($signed({1'b0, cal}));
    shifted = prod >>> FRAC_BITS;
    if (shifted > MAXV)
      cur = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < MINV)
      cur = {1'b1, {(OUT_W-1){1'b0}}};
    else
      cur = shifted[OUT_W-1:0];
    cext = {cur[OUT_W-1], cur};
    mag  = (cext < 0) ? $unsigned(-cext) : $unsigned(cext);
  end
endmodule

// File: rtl/pcalc_divider.sv
module pcalc_divider
  import pcalc_pkg::*;
#(
  parameter int NW      = 34,
  parameter int DIVISOR = 5000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  output logic          busy,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int RW = $clog2(DIVISOR);
  localparam int CW = $clog2(NW + 1);
  localparam logic [RW:0] DIV_V = (RW+1)'(DIVISOR);

  div_st_t       st;
  logic [RW-1:0] rem;
  logic [NW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [RW:0]   rem_sh;
  logic          ge;
  logic [RW-1:0] rem_nx;

  always_comb begin
    rem_sh = {rem, acc[NW-1]};
    ge     = (rem_sh >= DIV_V);
    rem_nx = ge ? RW'(rem_sh - DIV_V) : rem_sh[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= DIV_IDLE;
      rem <= '0;
      acc <= '0;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        DIV_IDLE: begin
          if (start) begin
            acc <= num;
            rem <= '0;
            cnt <= '0;
            st  <= DIV_RUN;
          end
        end
        default: begin
          rem <= rem_nx;
          acc <= {acc[NW-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NW - 1)) begin
            st  <= DIV_IDLE;
            fin <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (st == DIV_RUN);
  assign quo  = acc;

  // R9
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

  // R9
  fin_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(st == DIV_RUN));
endmodule

// File: rtl/cal_power_calc.sv
module cal_power_calc #(
  parameter int SHUNT_W     = 16,
  parameter int BUS_W       = 16,
  parameter int CAL_W       = 16,
  parameter int OUT_W       = 16,
  parameter int PWR_W       = 16,
  parameter int FRAC_BITS   = 12,
  parameter int POWER_SCALE = 5000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cal_we,
  input  logic [CAL_W-1:0]         cal_wdata,
  input  logic                     conv_valid,
  input  logic signed [SHUNT_W-1:0] shunt_in,
  input  logic [BUS_W-1:0]         bus_in,
  input  logic                     bus_range_hi,
  output logic signed [OUT_W-1:0]  current_out,
  output logic [PWR_W-1:0]         power_out,
  output logic [CAL_W-1:0]         cal_out,
  output logic                     done
);
  localparam int NUM_W = OUT_W + 1 + BUS_W + 1;
  localparam logic [NUM_W-1:0] PWR_MAX = NUM_W'({PWR_W{1'b1}});

  logic [CAL_W-1:0]         cal_q;
  logic signed [OUT_W-1:0]  cur_c;
  logic [OUT_W:0]           mag_c;
  logic signed [OUT_W-1:0]  cur_hold;
  logic [NUM_W-1:0]         prod_c;
  logic [NUM_W-1:0]         num_c;
  logic                     busy;
  logic                     fin;
  logic [NUM_W-1:0]         quo;
  logic                     start;

  always_ff @(posedge clk) begin
    if (rst) cal_q <= '0;
    else if (cal_we) cal_q <= cal_wdata;
  end
  assign cal_out = cal_q;

  pcalc_cur_scale #(
    .SHUNT_W(SHUNT_W), .CAL_W(CAL_W), .FRAC_BITS(FRAC_BITS), .OUT_W(OUT_W)
  ) scale_i (
    .shunt(shunt_in), .cal(cal_q), .cur(cur_c), .mag(mag_c)
  );

  always_comb begin
    prod_c = NUM_W'(mag_c) * NUM_W'(bus_in);
    num_c  = bus_range_hi ? (prod_c << 1) : prod_c;
  end

  assign start = conv_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) cur_hold <= '0;
    else if (start) cur_hold <= cur_c;
  end

  pcalc_divider #(.NW(NUM_W), .DIVISOR(POWER_SCALE)) div_i (
    .clk(clk), .rst(rst), .start(start), .num(num_c),
    .busy(busy), .fin(fin), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      current_out <= '0;
      power_out   <= '0;
      done        <= 1'b0;
    end else begin
      done <= fin;
      if (cal_q == '0) begin
        current_out <= '0;
        power_out   <= '0;
      end else if (fin) begin
        current_out <= cur_hold;
        power_out   <= (quo > PWR_MAX) ? {PWR_W{1'b1}} : quo[PWR_W-1:0];
      end
    end
  end

  // R8
  cal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cal_q) == '0) |-> (current_out == '0 && power_out == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(cal_q) != '0) |-> ($stable(current_out) && $stable(power_out)));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && busy) |=> $stable(cur_hold));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/cal_power_calc_tb.sv
module cal_power_calc_tb_top;
  localparam int LAT = 35;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cal_we = 1'b0;
  logic [15:0]        cal_wdata = '0;
  logic               conv_valid = 1'b0;
  logic signed [15:0] shunt_in = '0;
  logic [15:0]        bus_in = '0;
  logic               bus_range_hi = 1'b0;
  logic signed [15:0] current_out;
  logic [15:0]        power_out;
  logic [15:0]        cal_out;
  logic               done;

  int checks = 0;
  int errors = 0;
  logic [15:0] cal_now = '0;

  always #2 clk = ~clk;

  cal_power_calc dut_i (
    .clk(clk), .rst(rst), .cal_we(cal_we), .cal_wdata(cal_wdata),
    .conv_valid(conv_valid), .shunt_in(shunt_in), .bus_in(bus_in),
    .bus_range_hi(bus_range_hi), .current_out(current_out),
    .power_out(power_out), .cal_out(cal_out), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_cur(input longint sh, input longint cal);
    longint p = (sh * cal) >>> 12;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return p;
  endfunction

  function automatic longint exp_pwr(input longint cur, input longint bus, input bit hi);
    longint m = (cur < 0) ? -cur : cur;
    longint q = (m * bus * (hi ? 2 : 1)) / 5000;
    return (q > 65535) ? 65535 : q;
  endfunction

  task automatic write_cal(input logic [15:0] v);
    @(negedge clk);
    cal_we = 1'b1; cal_wdata = v;
    @(negedge clk);
    cal_we = 1'b0;
    cal_now = v;
    check("R2 cal readback", cal_out, v);
  endtask

  task automatic run_conv(input string req, input logic signed [15:0] sh,
                          input logic [15:0] bus, input bit hi);
    int n = 0;
    longint ec;
    @(negedge clk);
    shunt_in = sh; bus_in = bus; bus_range_hi = hi; conv_valid = 1'b1;
    @(posedge clk); #1;
    conv_valid = 1'b0;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); #1;
      if (done) begin n = k; break; end
    end
    check({req, " R9 latency"}, n, LAT);
    ec = (cal_now == 0) ? 0 : exp_cur(sh, cal_now);
    check({req, " current"}, current_out, ec);
    check({req, " power"}, power_out, (cal_now == 0) ? 0 : exp_pwr(ec, bus, hi));
    @(posedge clk); #1;
    check({req, " R9 done one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    check("R1 current", current_out, 0);
    check("R1 power", power_out, 0);
    check("R1 cal", cal_out, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_basic;
    write_cal(16'd4096);
    run_conv("R3 R5 identity", 16'sd1000, 16'd2500, 1'b0);
    run_conv("R3 R5 negative", -16'sd12000, 16'd40000, 1'b0);
    write_cal(16'd1365);
    run_conv("R3 floor negative", -16'sd3, 16'd5000, 1'b0);
    run_conv("R3 odd cal", 16'sd29999, 16'd777, 1'b0);
  endtask

  task automatic t_range;
    write_cal(16'd4096);
    run_conv("R6 high range", 16'sd1234, 16'd9876, 1'b1);
    run_conv("R6 high range neg", -16'sd7, 16'd1000, 1'b1);
  endtask

  task automatic t_saturate;
    write_cal(16'hFFFF);
    run_conv("R4 positive clamp", 16'sd32767, 16'd100, 1'b0);
    run_conv("R4 negative clamp", -16'sd32768, 16'd100, 1'b0);
    run_conv("R7 power clamp", -16'sd32768, 16'hFFFF, 1'b1);
  endtask

  task automatic t_busy;
    int extra = 0;
    write_cal(16'd4096);
    @(negedge clk);
    shunt_in = 16'sd500; bus_in = 16'd3000; bus_range_hi = 1'b0; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
    repeat (5) @(negedge clk);
    shunt_in = -16'sd9000; bus_in = 16'd60000; bus_range_hi = 1'b1; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1;
      if (done) break;
    end
    check("R10 current from first strobe", current_out, 500);
    check("R10 power from first strobe", power_out, exp_pwr(500, 3000, 1'b0));
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    check("R10 no second done", extra, 0);
  endtask

  task automatic t_calzero;
    write_cal(16'd4096);
    run_conv("R8 before clear", 16'sd2000, 16'd2000, 1'b0);
    write_cal(16'd0);
    @(negedge clk);
    check("R8 current cleared", current_out, 0);
    check("R8 power cleared", power_out, 0);
    run_conv("R8 conv while zero", 16'sd2000, 16'd2000, 1'b0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_range();
    t_saturate();
    t_busy();
    t_calzero();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule